// File: doc/BRIEF.md
# Stage-1 Translation Table Walker

This block turns a 64-bit input address into an output address by walking four-level stage-1 translation tables with a 4 KiB granule. A walk starts on a one-cycle `start` pulse. The block first picks the lower or the upper table region, checking the top address bits against each region's size field. Bit 55 of the address selects which top-byte-ignore flag applies, so the top byte can be left out of that check.

The walker then reads 8-byte descriptors one at a time over a simple read port: a one-cycle request followed later by one response beat, with one read outstanding. It follows table descriptors downward until it reaches a page or a block. Along the way it checks table-level write protection, the access flag and the leaf write protection.

The result is held at the outputs from the one-cycle `done` pulse until the next walk starts. A successful walk gives the output address, the aligned input address, the mapping mask, the permission and the level. A failed walk gives a fault type, the stage number and the address of the failing read.

Top module: `ptw_stage1_walker`

## Requirements
- R1: Region choice uses address bit 55 to pick the top-byte-ignore flag (bit 55 = 0 uses `cfgTbi0`, 1 uses `cfgTbi1`). The checked bits are [63:64-tsz], and bits [63:56] are left out of that range when the flag is set. The lower region wins when its size field is nonzero and the checked bits are all zero. Otherwise the upper region is used when its size field is nonzero and its checked bits are all ones.
- R2: If neither region claims the address, a region whose size field is zero takes it, the lower region first. An address between two sized regions, or one that selects a disabled region, ends with fault type 1 (translation) and issues no read.
- R3: The input size is 64 - tsz. The start level is the lowest level L whose shift 12+9*(3-L) is below the input size: tsz 16..24 starts at level 0, 25..33 at level 1, 34..42 at level 2. The root base is table-base bits [47:0] with the low (n+3) bits cleared, where n is the input size minus the start-level shift, limited to 1..9. The first read is at root base + index*8.
- R4: A response with `memRspErr` set ends the walk with fault type 2 (external abort on walk), and `faultAddr` holds the address of that read.
- R5: Descriptor bits [1:0] = 00 or 10 (invalid), or 01 at level 3 (reserved), end the walk with fault type 1.
- R6: Descriptor bits [1:0] = 11 below level 3 mark a table. Its bits [47:12] become the next level's base. If its bit 62 is set, a write access takes fault type 4, unless the selected region's hierarchical-permission-disable input is set.
- R7: A leaf is bits 11 at level 3 (page) or 01 below level 3 (block). On success the block outputs:
  - `outAddr`: the descriptor bits [47:s] with the lower s bits zero;
  - `alignedVa`: the input address with bits [s-1:0] cleared;
  - `addrMask`: 2^s - 1;
  - `outLevel`: the leaf's level;
  - `granuleLog2`: 12.

  Here s = 12+9*(3-level).
- R8: A leaf whose access flag (bit 10) is 0 gives fault type 3 (access) when `cfgAfFaultDis` is 0. This fault takes priority over a permission fault on the same descriptor.
- R9: Leaf bit 7 set marks the mapping read-only, and a write to it gives fault type 4 (permission). On success `perm` is 2'b01 for read-only and 2'b11 for read-write.
- R10: Any fault sets `fault`, reports `faultStage` = 1 and forces `perm` to 2'b00. A successful walk reports stage 0 and fault type 0.
- R11: `memReq` is a one-cycle pulse with at most one read outstanding. `done` is a one-cycle pulse in the cycle after the deciding response or the rejecting start. After reset `busy`, `done` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted while idle) |
| inVa | input | 64 | Input address to translate |
| isWrite | input | 1 | Access is a write |
| cfgTsz0 | input | 6 | Lower region size field |
| cfgTsz1 | input | 6 | Upper region size field |
| cfgTbi0 | input | 1 | Top-byte-ignore when bit 55 is 0 |
| cfgTbi1 | input | 1 | Top-byte-ignore when bit 55 is 1 |
| cfgOff0 | input | 1 | Lower region disabled |
| cfgOff1 | input | 1 | Upper region disabled |
| cfgHpd0 | input | 1 | Lower region ignores table permissions |
| cfgHpd1 | input | 1 | Upper region ignores table permissions |
| cfgTtb0 | input | 64 | Lower region table base |
| cfgTtb1 | input | 64 | Upper region table base |
| cfgAfFaultDis | input | 1 | Suppress access-flag faults |
| memReq | output | 1 | Descriptor read request pulse |
| memAddr | output | PA_W | Descriptor read address |
| memRspValid | input | 1 | Read response beat |
| memRspData | input | 64 | Descriptor value |
| memRspErr | input | 1 | Read failed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Walk failed |
| faultType | output | 3 | 0 none, 1 translation, 2 walk abort, 3 access, 4 permission |
| faultStage | output | 2 | 1 on fault, else 0 |
| faultAddr | output | PA_W | Address of the failing read (0 for a region fault) |
| outAddr | output | PA_W | Translated output base |
| alignedVa | output | 64 | Input address aligned to the mapping |
| addrMask | output | 64 | Mapping size minus one |
| perm | output | 2 | {write, read} permission |
| outLevel | output | 2 | Level of the leaf or fault |
| granuleLog2 | output | 6 | Granule size log2 (12) |

## Verification
A wrong level or base register shows up at the port on the very next `memReq`. The read address leaves the arithmetic table layout, and the walk then takes a different number of reads than the leaf level implies, so the error appears within one descriptor fetch. A corrupted region choice or start level is visible at the first read address. A wrong fault priority or permission latch shows as a wrong `faultType` or `perm` on the `done` pulse of that same walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int GRAN_LOG2 = 12;
  localparam int STRIDE = 9;
  localparam int LAST_LVL = 3;
  localparam int DESC_BYTES_LOG2 = 3;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_XLATE  = 3'd1,
    FLT_EXTABT = 3'd2,
    FLT_ACCESS = 3'd3,
    FLT_PERM   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    DEC_TABLE = 2'd0,
    DEC_LEAF  = 2'd1,
    DEC_FAULT = 2'd2
  } dec_e;

  typedef struct packed {
    logic capture;
    logic step;
  } strobe_t;

  function automatic int levelShift(input logic [1:0] lvl);
    return GRAN_LOG2 + STRIDE * (LAST_LVL - int'(lvl));
  endfunction
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    selFault,
  input  dec_e    dec,
  input  logic    memRspValid,
  output strobe_t st,
  output logic    memReq,
  output logic    busy,
  output logic    done
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    st = '0;
    case (state)
      S_IDLE: if (start) begin
        st.capture = 1'b1;
        stateNext = selFault ? S_DONE : S_REQ;
      end
      S_REQ: stateNext = S_WAIT;
      S_WAIT: if (memRspValid) begin
        st.step = 1'b1;
        stateNext = (dec == DEC_TABLE) ? S_REQ : S_DONE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else state <= stateNext;
  end

  assign memReq = (state == S_REQ);
  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         st,
  input  logic [63:0]     inVa,
  input  logic            isWrite,
  input  logic [5:0]      cfgTsz0,
  input  logic [5:0]      cfgTsz1,
  input  logic            cfgTbi0,
  input  logic            cfgTbi1,
  input  logic            cfgOff0,
  input  logic            cfgOff1,
  input  logic            cfgHpd0,
  input  logic            cfgHpd1,
  input  logic [63:0]     cfgTtb0,
  input  logic [63:0]     cfgTtb1,
  input  logic            cfgAfFaultDis,
  input  logic [63:0]     memRspData,
  input  logic            memRspErr,
  output logic            selFault,
  output dec_e            dec,
  output logic [PA_W-1:0] memAddr,
  output logic            fault,
  output logic [2:0]      faultType,
  output logic [1:0]      faultStage,
  output logic [PA_W-1:0] faultAddr,
  output logic [PA_W-1:0] outAddr,
  output logic [63:0]     alignedVa,
  output logic [63:0]     addrMask,
  output logic [1:0]      perm,
  output logic [1:0]      outLevel
);
  localparam int IDX_W = STRIDE;

  function automatic logic [63:0] upperMask(input logic [5:0] tsz, input logic tbi);
    logic [63:0] m;
    for (int i = 0; i < 64; i++)
      m[i] = ((i + int'(tsz)) >= 64) && !(tbi && (i >= 56));
    return m;
  endfunction

  // walk state
  logic [63:0]      vaQ;
  logic             wrQ, hpdQ, afDisQ, atStartQ;
  logic [1:0]       lvlQ;
  logic [PA_W-1:0]  baseQ;
  logic [IDX_W-1:0] firstMaskQ;

  // region selection (combinational on the request inputs)
  logic             tbiSel, in0, in1, selOk, selR, selHpd;
  logic [63:0]      m0, m1, selTtb;
  logic [5:0]       selTsz;
  logic [1:0]       startLvl;
  logic [IDX_W-1:0] firstMask;
  logic [PA_W-1:0]  rootBase;

  always_comb begin
    int inSz;
    int sBits;
    tbiSel = inVa[55] ? cfgTbi1 : cfgTbi0;
    m0 = upperMask(cfgTsz0, tbiSel);
    m1 = upperMask(cfgTsz1, tbiSel);
    in0 = (cfgTsz0 != 6'd0) && ((inVa & m0) == 64'd0);
    in1 = (cfgTsz1 != 6'd0) && ((inVa & m1) == m1);
    selOk = 1'b1;
    selR = 1'b0;
    if (in0) selR = 1'b0;
    else if (in1) selR = 1'b1;
    else if (cfgTsz0 == 6'd0) selR = 1'b0;
    else if (cfgTsz1 == 6'd0) selR = 1'b1;
    else selOk = 1'b0;
    selFault = !selOk || (selR ? cfgOff1 : cfgOff0);
    selTsz = selR ? cfgTsz1 : cfgTsz0;
    selTtb = selR ? cfgTtb1 : cfgTtb0;
    selHpd = selR ? cfgHpd1 : cfgHpd0;
    inSz = 64 - int'(selTsz);
    startLvl = 2'd3;
    for (int l = LAST_LVL; l >= 0; l--)
      if (inSz > levelShift(2'(l))) startLvl = 2'(l);
    sBits = inSz - levelShift(startLvl);
    if (sBits > STRIDE) sBits = STRIDE;
    if (sBits < 1) sBits = 1;
    firstMask = IDX_W'((64'd1 << sBits) - 64'd1);
    rootBase = selTtb[PA_W-1:0] & ~PA_W'((64'd1 << (sBits + DESC_BYTES_LOG2)) - 64'd1);
  end

  // descriptor address and decode
  logic [63:0]      shifted, lvlMask;
  logic [IDX_W-1:0] idx;
  logic [1:0]       dType;
  fault_e           decFault;

  always_comb begin
    shifted = vaQ >> levelShift(lvlQ);
    idx = shifted[IDX_W-1:0] & (atStartQ ? firstMaskQ : {IDX_W{1'b1}});
    memAddr = baseQ + PA_W'({idx, {DESC_BYTES_LOG2{1'b0}}});
    lvlMask = (64'd1 << levelShift(lvlQ)) - 64'd1;
    dType = memRspData[1:0];
    dec = DEC_FAULT;
    decFault = FLT_XLATE;
    if (memRspErr) decFault = FLT_EXTABT;
    else if (dType == 2'b11 && lvlQ != 2'(LAST_LVL)) begin
      if (!hpdQ && wrQ && memRspData[62]) decFault = FLT_PERM;
      else dec = DEC_TABLE;
    end else if (dType == 2'b11 || (dType == 2'b01 && lvlQ != 2'(LAST_LVL))) begin
      if (!memRspData[10] && !afDisQ) decFault = FLT_ACCESS;
      else if (wrQ && memRspData[7]) decFault = FLT_PERM;
      else dec = DEC_LEAF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ <= '0; wrQ <= 1'b0; hpdQ <= 1'b0; afDisQ <= 1'b0; atStartQ <= 1'b0;
      lvlQ <= '0; baseQ <= '0; firstMaskQ <= '0;
      fault <= 1'b0; faultType <= FLT_NONE; faultAddr <= '0; outAddr <= '0;
      alignedVa <= '0; addrMask <= '0; perm <= 2'b00; outLevel <= '0;
    end else if (st.capture) begin
      vaQ <= inVa; wrQ <= isWrite; hpdQ <= selHpd; afDisQ <= cfgAfFaultDis;
      lvlQ <= startLvl; baseQ <= rootBase; atStartQ <= 1'b1; firstMaskQ <= firstMask;
      fault <= selFault; faultType <= selFault ? FLT_XLATE : FLT_NONE;
      faultAddr <= '0; outAddr <= '0; alignedVa <= '0; addrMask <= '0;
      perm <= 2'b00; outLevel <= startLvl;
    end else if (st.step) begin
      outLevel <= lvlQ;
      case (dec)
        DEC_TABLE: begin
          baseQ <= {memRspData[PA_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
          lvlQ <= lvlQ + 2'd1;
          atStartQ <= 1'b0;
        end
        DEC_LEAF: begin
          fault <= 1'b0; faultType <= FLT_NONE;
          outAddr <= memRspData[PA_W-1:0] & ~lvlMask[PA_W-1:0];
          alignedVa <= vaQ & ~lvlMask;
          addrMask <= lvlMask;
          perm <= memRspData[7] ? 2'b01 : 2'b11;
        end
        default: begin
          fault <= 1'b1; faultType <= decFault; faultAddr <= memAddr;
          perm <= 2'b00;
        end
      endcase
    end
  end

  assign faultStage = fault ? 2'd1 : 2'd0;
endmodule

// File: rtl/ptw_stage1_walker.sv
module ptw_stage1_walker
  import ptw_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [63:0]     inVa,
  input  logic            isWrite,
  input  logic [5:0]      cfgTsz0,
  input  logic [5:0]      cfgTsz1,
  input  logic            cfgTbi0,
  input  logic            cfgTbi1,
  input  logic            cfgOff0,
  input  logic            cfgOff1,
  input  logic            cfgHpd0,
  input  logic            cfgHpd1,
  input  logic [63:0]     cfgTtb0,
  input  logic [63:0]     cfgTtb1,
  input  logic            cfgAfFaultDis,
  output logic            memReq,
  output logic [PA_W-1:0] memAddr,
  input  logic            memRspValid,
  input  logic [63:0]     memRspData,
  input  logic            memRspErr,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [2:0]      faultType,
  output logic [1:0]      faultStage,
  output logic [PA_W-1:0] faultAddr,
  output logic [PA_W-1:0] outAddr,
  output logic [63:0]     alignedVa,
  output logic [63:0]     addrMask,
  output logic [1:0]      perm,
  output logic [1:0]      outLevel,
  output logic [5:0]      granuleLog2
);
  strobe_t st;
  logic    selFault;
  dec_e    dec;

  ptw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .selFault(selFault), .dec(dec),
    .memRspValid(memRspValid), .st(st), .memReq(memReq), .busy(busy), .done(done)
  );

  ptw_datapath #(.PA_W(PA_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .inVa(inVa), .isWrite(isWrite),
    .cfgTsz0(cfgTsz0), .cfgTsz1(cfgTsz1), .cfgTbi0(cfgTbi0), .cfgTbi1(cfgTbi1),
    .cfgOff0(cfgOff0), .cfgOff1(cfgOff1), .cfgHpd0(cfgHpd0), .cfgHpd1(cfgHpd1),
    .cfgTtb0(cfgTtb0), .cfgTtb1(cfgTtb1), .cfgAfFaultDis(cfgAfFaultDis),
    .memRspData(memRspData), .memRspErr(memRspErr), .selFault(selFault), .dec(dec),
    .memAddr(memAddr), .fault(fault), .faultType(faultType), .faultStage(faultStage),
    .faultAddr(faultAddr), .outAddr(outAddr), .alignedVa(alignedVa),
    .addrMask(addrMask), .perm(perm), .outLevel(outLevel)
  );

  assign granuleLog2 = 6'(GRAN_LOG2);
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 48
) (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        done,
  input logic        fault,
  input logic [2:0]  faultType,
  input logic [1:0]  faultStage,
  input logic [1:0]  perm,
  input logic [63:0] alignedVa,
  input logic [63:0] addrMask
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R11
  AST_REQ_NOT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq); // R11
  AST_FAULT_PERM_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (perm == 2'b00 && faultStage == 2'd1 && faultType != 3'd0)); // R10
  AST_OK_STAGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (faultStage == 2'd0 && faultType == 3'd0)); // R10
  AST_LEAF_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> ((alignedVa & addrMask) == 64'd0)); // R7
  AST_PERM_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (perm == 2'b01 || perm == 2'b11)); // R9
endmodule

bind ptw_stage1_walker ptw_walker_chk #(.PA_W(PA_W)) uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .done(done), .fault(fault),
  .faultType(faultType), .faultStage(faultStage), .perm(perm),
  .alignedVa(alignedVa), .addrMask(addrMask)
);

// File: tb/tb_ptw_stage1_walker.sv
`timescale 1ns/1ps
module tb_ptw_stage1_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        start = 0, isWrite = 0;
  logic [63:0] inVa = '0;
  logic [5:0]  cfgTsz0, cfgTsz1;
  logic        cfgTbi0, cfgTbi1, cfgOff0, cfgOff1, cfgHpd0, cfgHpd1, cfgAfFaultDis;
  logic [63:0] cfgTtb0, cfgTtb1;
  logic        memReq, memRspValid = 0, memRspErr = 0;
  logic [47:0] memAddr, faultAddr, outAddr;
  logic [63:0] memRspData = '0, alignedVa, addrMask;
  logic        busy, done, fault;
  logic [2:0]  faultType;
  logic [1:0]  faultStage, perm, outLevel;
  logic [5:0]  granuleLog2;

  ptw_stage1_walker #(.PA_W(48)) dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [63:0] mem [logic [47:0]];
  logic        errEn = 0;
  logic [47:0] errAddr = '0;
  int          nReq = 0;
  logic [47:0] firstAddr = '0;
  logic [47:0] descAddr [4];
  bit          pend = 0;
  int          cnt = 0;
  logic [47:0] reqAddr = '0;

  always @(negedge clk) begin
    memRspValid <= 1'b0;
    memRspErr <= 1'b0;
    if (memReq) begin
      pend = 1; cnt = nReq % 3; reqAddr = memAddr;
      if (nReq == 0) firstAddr = memAddr;
      nReq++;
    end else if (pend) begin
      if (cnt == 0) begin
        memRspValid <= 1'b1;
        memRspData <= mem.exists(reqAddr) ? mem[reqAddr] : 64'd0;
        memRspErr <= errEn && (reqAddr == errAddr);
        pend = 0;
      end else cnt--;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setDefault();
    cfgTsz0 = 6'd16; cfgTsz1 = 6'd16; cfgTbi0 = 0; cfgTbi1 = 0;
    cfgOff0 = 0; cfgOff1 = 0; cfgHpd0 = 0; cfgHpd1 = 0;
    cfgTtb0 = 64'h0000_0000_0001_0000; cfgTtb1 = 64'h0000_0000_0002_0000;
    cfgAfFaultDis = 0; errEn = 0;
  endtask

  function automatic logic [47:0] idxOf(input logic [63:0] va, input int lvl);
    logic [63:0] s;
    s = va >> (12 + 9 * (3 - lvl));
    return 48'(s[8:0]);
  endfunction

  function automatic logic [63:0] maskOf(input int lvl);
    return (64'd1 << (12 + 9 * (3 - lvl))) - 64'd1;
  endfunction

  task automatic buildChain(input logic [47:0] root, input logic [63:0] va, input int leafL,
                            input logic [63:0] leafD, input int roLvl);
    logic [47:0] t, nxt;
    logic [63:0] d;
    mem.delete();
    t = root;
    for (int l = 0; l < leafL; l++) begin
      nxt = 48'h20_0000 + 48'(l) * 48'h1000;
      d = 64'(nxt) | 64'd3;
      if (l == roLvl) d[62] = 1'b1;
      descAddr[l] = t + idxOf(va, l) * 8;
      mem[descAddr[l]] = d;
      t = nxt;
    end
    descAddr[leafL] = t + idxOf(va, leafL) * 8;
    mem[descAddr[leafL]] = leafD;
  endtask

  task automatic runWalk(input logic [63:0] va, input logic wr);
    @(negedge clk);
    inVa = va; isWrite = wr; start = 1; nReq = 0;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    if (!done) chk("R11 walk completes", 0, 1);
  endtask

  task automatic expectOk(input string tag, input logic [63:0] va, input int lvl,
                          input logic [47:0] oa, input logic ro);
    logic [63:0] m;
    m = maskOf(lvl);
    chk({tag, " R10 fault"}, 64'(fault), 0);
    chk({tag, " R10 type"}, 64'(faultType), 0);
    chk({tag, " R10 stage"}, 64'(faultStage), 0);
    chk({tag, " R7 outAddr"}, 64'(outAddr), 64'(oa & ~m[47:0]));
    chk({tag, " R7 alignedVa"}, alignedVa, va & ~m);
    chk({tag, " R7 addrMask"}, addrMask, m);
    chk({tag, " R7 level"}, 64'(outLevel), 64'(lvl));
    chk({tag, " R7 granule"}, 64'(granuleLog2), 12);
    chk({tag, " R9 perm"}, 64'(perm), ro ? 64'd1 : 64'd3);
  endtask

  task automatic expectFault(input string tag, input int code);
    chk({tag, " fault"}, 64'(fault), 1);
    chk({tag, " type"}, 64'(faultType), 64'(code));
    chk({tag, " R10 stage"}, 64'(faultStage), 1);
    chk({tag, " R10 perm"}, 64'(perm), 0);
  endtask

  localparam logic [63:0] VA0 = 64'h0000_5A5A_C3C3_9F18;
  localparam logic [63:0] VA1 = 64'hFFFF_A5A5_3C3C_6E27;
  localparam logic [47:0] OA  = 48'h8765_4321_F000;

  initial begin
    logic [63:0] va, ld, m;
    logic [47:0] root;
    setDefault();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R11 reset done", 64'(done), 0);
    chk("R11 reset busy", 64'(busy), 0);
    chk("R11 reset memReq", 64'(memReq), 0);

    // sweep: region x leaf level x access x AF x AP
    for (int r = 0; r < 2; r++)
      for (int l = 0; l < 4; l++)
        for (int wr = 0; wr < 2; wr++)
          for (int af = 0; af < 2; af++)
            for (int ro = 0; ro < 2; ro++) begin
              va = r ? VA1 : VA0;
              root = r ? cfgTtb1[47:0] : cfgTtb0[47:0];
              m = maskOf(l);
              ld = 64'(OA & ~m[47:0]) | (64'(af) << 10) | (64'(ro) << 7) | ((l == 3) ? 64'd3 : 64'd1);
              buildChain(root, va, l, ld, -1);
              runWalk(va, wr[0]);
              if (af == 0) expectFault("R8 access fault first", 3);
              else if (wr == 1 && ro == 1) expectFault("R9 write to read-only", 4);
              else expectOk("R7 leaf", va, l, OA, ro[0]);
              chk("R6 fetch count", 64'(nReq), 64'(l + 1));
              chk("R1 root fetch", 64'(firstAddr), 64'(root + idxOf(va, 0) * 8));
            end
    @(negedge clk);
    chk("R11 done is one pulse", 64'(done), 0);

    // AF fault suppressed
    cfgAfFaultDis = 1;
    buildChain(cfgTtb0[47:0], VA0, 3, 64'(OA) | (64'd1 << 7) | 64'd3, -1);
    runWalk(VA0, 1);
    expectFault("R8 afDis then R9 perm", 4);
    runWalk(VA0, 0);
    expectOk("R8 afDis read", VA0, 3, OA, 1);
    cfgAfFaultDis = 0;

    // walk abort at each level
    for (int k = 0; k < 4; k++) begin
      buildChain(cfgTtb0[47:0], VA0, 3, 64'(OA) | (64'd1 << 10) | 64'd3, -1);
      errEn = 1; errAddr = descAddr[k];
      runWalk(VA0, 0);
      expectFault("R4 walk abort", 2);
      chk("R4 abort address", 64'(faultAddr), 64'(descAddr[k]));
      chk("R4 reads stop", 64'(nReq), 64'(k + 1));
      errEn = 0;
    end

    // invalid descriptors at each level, reserved at level 3
    for (int k = 0; k < 4; k++)
      for (int code = 0; code < 3; code += 2) begin
        buildChain(cfgTtb0[47:0], VA0, 3, 64'(OA) | (64'd1 << 10) | 64'd3, -1);
        mem[descAddr[k]] = 64'(OA) | (64'd1 << 10) | 64'(code);
        runWalk(VA0, 0);
        expectFault("R5 invalid descriptor", 1);
        chk("R5 level of invalid", 64'(outLevel), 64'(k));
      end
    buildChain(cfgTtb0[47:0], VA0, 3, 64'(OA) | (64'd1 << 10) | 64'd1, -1);
    runWalk(VA0, 0);
    expectFault("R5 reserved at level 3", 1);

    // table write protection
    buildChain(cfgTtb0[47:0], VA0, 3, 64'(OA) | (64'd1 << 10) | 64'd3, 1);
    runWalk(VA0, 1);
    expectFault("R6 table write protect", 4);
    chk("R6 stops at table", 64'(nReq), 2);
    runWalk(VA0, 0);
    expectOk("R6 table read allowed", VA0, 3, OA, 0);
    cfgHpd0 = 1;
    runWalk(VA0, 1);
    expectOk("R6 hierarchical disabled", VA0, 3, OA, 0);
    cfgHpd0 = 0;

    // top-byte-ignore and region choice
    va = 64'hAB00_1234_5678_9000;
    cfgTbi0 = 1;
    buildChain(cfgTtb0[47:0], va, 3, 64'(OA) | (64'd1 << 10) | 64'd3, -1);
    runWalk(va, 0);
    expectOk("R1 tbi0 lower region", va, 3, OA, 0);
    cfgTbi0 = 0;
    runWalk(va, 0);
    expectFault("R2 gap without tbi", 1);
    chk("R2 gap issues no read", 64'(nReq), 0);
    va = 64'h12FF_FFFF_8765_4000;
    cfgTbi1 = 1;
    buildChain(cfgTtb1[47:0], va, 3, 64'(OA) | (64'd1 << 10) | 64'd3, -1);
    runWalk(va, 0);
    expectOk("R1 tbi1 upper region", va, 3, OA, 0);
    chk("R1 upper root", 64'(firstAddr), 64'(cfgTtb1[47:0] + idxOf(va, 0) * 8));
    cfgTbi1 = 0;
    va = 64'h8000_0000_0000_1000;
    cfgTsz1 = 0;
    mem.delete();
    runWalk(va, 0);
    chk("R2 zero-size upper takes rest", 64'(firstAddr), 64'(cfgTtb1[47:0] + idxOf(va, 0) * 8));
    cfgTsz1 = 16; cfgTsz0 = 0;
    va = 64'h1234_0000_0000_0000;
    runWalk(va, 0);
    chk("R2 zero-size lower takes rest", 64'(firstAddr), 64'(cfgTtb0[47:0] + idxOf(va, 0) * 8));
    cfgTsz0 = 16;
    cfgOff0 = 1;
    runWalk(VA0, 0);
    expectFault("R2 disabled lower", 1);
    chk("R2 disabled no read", 64'(nReq), 0);
    cfgOff0 = 0; cfgOff1 = 1;
    runWalk(VA1, 0);
    expectFault("R2 disabled upper", 1);
    cfgOff1 = 0;

    // start level and root alignment
    mem.delete();
    cfgTsz0 = 6'd33; cfgTtb0 = 64'hF00D_0000_0012_345C;
    runWalk(64'h0000_0000_4000_0000, 0);
    chk("R3 tsz33 first read", 64'(firstAddr), 64'h12_3458);
    chk("R3 tsz33 start level", 64'(outLevel), 1);
    cfgTsz0 = 6'd25; cfgTtb0 = 64'h0000_0000_0004_5678;
    runWalk(64'h0000_0055_4000_0000, 0);
    chk("R3 tsz25 first read", 64'(firstAddr), 64'h4_5AA8);
    cfgTsz0 = 6'd36; cfgTtb0 = 64'h0000_0000_0007_7FFF;
    runWalk(64'h0000_0000_0A60_0000, 0);
    chk("R3 tsz36 first read", 64'(firstAddr), 64'h7_7E98);
    chk("R3 tsz36 start level", 64'(outLevel), 2);
    chk("R3 one read", 64'(nReq), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule